// File: doc/BRIEF.md
# Partial Word Byte Store Unit

This block converts a request to store part of a register into exactly one aligned 32-bit memory write with byte enables. A request has a byte address, a 32-bit register value, a form select (begin or end) and a valid strobe. Memory is big-endian, so byte offset 0 of a word is bits 31:24 (the most significant lane).

In the begin form, the word is written from the addressed byte through the last byte of the word. The data comes from the low-order bytes of the value. In the end form, the word is written from its first byte up to, but not including, the addressed byte. The data comes from the high-order bytes of the value. In both forms every byte keeps its lane: byte i of the value lands in byte i of the word. The end form at offset 0 writes nothing. It still raises a probe-only flag, so that the surrounding logic checks write permission for the address. Three-byte cases are issued as a single beat and are never split.

The control is a two-state machine. In the state `ST_IDLE` no result is presented. In the state `ST_ISSUE` the registered result of the previous cycle's request is presented. There are three transitions:
- `ST_IDLE` to `ST_ISSUE` on a strobe.
- `ST_ISSUE` to `ST_ISSUE` on a back-to-back strobe.
- `ST_ISSUE` to `ST_IDLE` when no strobe arrives.

Top module: `bytestore_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it, `wr_req` and `probe_only` are 0 and `wr_be` is 4'b0000.
- R2: In the begin form (`req_end`=0), address offsets 0, 1, 2 and 3 give `wr_be` of 1111, 0111, 0011 and 0001. `wr_be[3]` is byte 0 (bits 31:24) and `wr_be[0]` is byte 3 (bits 7:0).
- R3: In the end form (`req_end`=1), address offsets 3, 2 and 1 give `wr_be` of 1110, 1100 and 1000, with the same lane numbering as R2.
- R4: In the end form at offset 0, `probe_only` is 1, `wr_req` is 0 and `wr_be` is 0000. `probe_only` is never 1 in any other case.
- R5: `wr_data` byte lane i equals the same lane of `req_data` when `wr_be` bit i is set, and is zero when that bit is clear.
- R6: `wr_addr` equals `req_addr` with its two low bits cleared.
- R7: A result appears in the cycle after the strobe and lasts one cycle. Back-to-back strobes give back-to-back results. A cycle without a strobe gives `wr_req`=0 and `probe_only`=0 in the following cycle.
- R8: Every write, including the three-byte cases, is one beat. Its enabled lanes are non-empty and contiguous, and they touch either byte 0 or byte 3 of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Byte address |
| req_data | input | 32 | Register value to store |
| req_end | input | 1 | 0 selects the begin form, 1 the end form |
| wr_addr | output | ADDR_W | Word-aligned write address |
| wr_data | output | 32 | Lane-positioned write data, disabled lanes zero |
| wr_be | output | 4 | Byte enables, bit 3 is byte 0 |
| wr_req | output | 1 | One-beat write request |
| probe_only | output | 1 | Permission probe with no data written |

## Verification
A stuck or wrong state register shows up at the ports in the very next cycle, in one of three ways:
- A result is missing after a strobe.
- A result lingers after an idle cycle.
- Both `wr_req` and `probe_only` are raised together.

A wrong lane decode shows immediately as a mask that differs from the expected pattern for one of the eight form and offset pairs. Data that leaks into disabled lanes is caught on the same beat. Every pair is driven in a directed pass, and random back-to-back and idle traffic covers the state transitions.

// File: rtl/bytestore_pkg.sv
package bytestore_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned LANES   = WORD_W / 8;
    localparam int unsigned OFF_W   = $clog2(LANES);

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } bs_state_e;

    typedef struct packed {
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] data;
        logic              probe;
    } bs_result_t;
endpackage

// File: rtl/bs_lane_decode.sv
module bs_lane_decode
    import bytestore_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    input  logic             end_form,
    output logic [LANES-1:0] be,
    output logic             probe
);
    logic [LANES-1:0] from_offset;

    // Lanes from the addressed byte to the end of the word (big-endian).
    assign from_offset = {LANES{1'b1}} >> offset;

    always_comb begin
        if (end_form) begin
            be    = ~from_offset;
            probe = (offset == '0);
        end else begin
            be    = from_offset;
            probe = 1'b0;
        end
    end
endmodule

// File: rtl/bs_lane_mask.sv
module bs_lane_mask
    import bytestore_pkg::*;
(
    input  logic [WORD_W-1:0] value,
    input  logic [LANES-1:0]  be,
    output logic [WORD_W-1:0] data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign data[8*g +: 8] = be[g] ? value[8*g +: 8] : 8'h00;
    end
endmodule

// File: rtl/bytestore_unit.sv
module bytestore_unit
    import bytestore_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_data,
    input  logic              req_end,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic [3:0]        wr_be,
    output logic              wr_req,
    output logic              probe_only
);
    bs_state_e  state_q, state_d;
    bs_result_t res_d, res_q;
    logic [ADDR_W-1:0] addr_q;

    bs_lane_decode u_decode (
        .offset   (req_addr[OFF_W-1:0]),
        .end_form (req_end),
        .be       (res_d.be),
        .probe    (res_d.probe)
    );

    bs_lane_mask u_mask (
        .value (req_data),
        .be    (res_d.be),
        .data  (res_d.data)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)  state_d = ST_ISSUE;
            ST_ISSUE: if (!req_valid) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            addr_q <= '0;
        end else if (req_valid) begin
            res_q  <= res_d;
            addr_q <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        end
    end

    always_comb begin
        wr_addr    = addr_q;
        wr_data    = res_q.data;
        wr_be      = '0;
        wr_req     = 1'b0;
        probe_only = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ISSUE: begin
                wr_be      = res_q.be;
                wr_req     = !res_q.probe;
                probe_only = res_q.probe;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bytestore_unit_chk.sv
module bytestore_unit_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [3:0]        wr_be,
    input logic              wr_req,
    input logic              probe_only
);
    p_probe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        probe_only |-> (!wr_req && wr_be == 4'b0000));

    p_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req || probe_only) |-> (wr_addr[1:0] == 2'b00));

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req || probe_only) |-> $past(req_valid));

    p_result_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (wr_req || probe_only));

    p_one_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> ((wr_be[3] || wr_be[0]) && $countones(wr_be) != 0
                    && wr_be != 4'b1010 && wr_be != 4'b0101 && wr_be != 4'b1001
                    && wr_be != 4'b1011 && wr_be != 4'b1101));

    p_zero_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> ((wr_be[3] || wr_data[31:24] == 8'h00) &&
                    (wr_be[2] || wr_data[23:16] == 8'h00) &&
                    (wr_be[1] || wr_data[15:8]  == 8'h00) &&
                    (wr_be[0] || wr_data[7:0]   == 8'h00)));
endmodule

bind bytestore_unit bytestore_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bytestore_unit_tb.sv
module bytestore_unit_tb;
    localparam int unsigned AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_data = '0;
    logic          req_end = 1'b0;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data;
    logic [3:0]    wr_be;
    logic          wr_req;
    logic          probe_only;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    bytestore_unit #(.ADDR_W(AW)) u_dut (.*);

    function automatic logic [3:0] exp_be(input logic e, input logic [1:0] off);
        logic [3:0] b;
        case (off)
            2'd0: b = 4'b1111;
            2'd1: b = 4'b0111;
            2'd2: b = 4'b0011;
            default: b = 4'b0001;
        endcase
        return e ? ~b : b;
    endfunction

    function automatic logic [31:0] exp_data(input logic [3:0] b, input logic [31:0] v);
        logic [31:0] d;
        for (int i = 0; i < 4; i++) d[8*i +: 8] = b[i] ? v[8*i +: 8] : 8'h00;
        return d;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Check the outputs produced by a request driven one cycle earlier.
    task automatic check_result(input logic v, input logic e, input logic [AW-1:0] a,
                                input logic [31:0] d);
        logic [3:0] b;
        b = exp_be(e, a[1:0]);
        if (!v) begin
            check("R7 idle wr_req", 64'(wr_req), 64'd0);
            check("R7 idle probe_only", 64'(probe_only), 64'd0);
        end else if (e && a[1:0] == 2'd0) begin
            check("R4 probe_only", 64'(probe_only), 64'd1);
            check("R4 wr_req", 64'(wr_req), 64'd0);
            check("R4 wr_be", 64'(wr_be), 64'd0);
            check("R6 wr_addr", 64'(wr_addr), 64'({a[AW-1:2], 2'b00}));
        end else begin
            check(e ? "R3 wr_be" : "R2 wr_be", 64'(wr_be), 64'(b));
            check("R7 wr_req", 64'(wr_req), 64'd1);
            check("R4 no probe", 64'(probe_only), 64'd0);
            check("R5 wr_data", 64'(wr_data), 64'(exp_data(b, d)));
            check("R6 wr_addr", 64'(wr_addr), 64'({a[AW-1:2], 2'b00}));
            if ($countones(b) == 3)
                check("R8 three-byte single beat", 64'(wr_be), 64'(b));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic          pv, pe;
        logic [AW-1:0] pa;
        logic [31:0]   pd;
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 wr_req in reset", 64'(wr_req), 64'd0);
        check("R1 probe_only in reset", 64'(probe_only), 64'd0);
        check("R1 wr_be in reset", 64'(wr_be), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 wr_req after reset", 64'(wr_req), 64'd0);
        check("R1 probe_only after reset", 64'(probe_only), 64'd0);

        // Directed: every form/offset pair back to back (R2, R3, R4, R8)
        pv = 1'b0; pe = 1'b0; pa = '0; pd = '0;
        for (int m = 0; m < 8; m++) begin
            req_valid = 1'b1;
            req_end   = m[2];
            req_addr  = {30'h1234_5678 + 30'(m), 2'(m)};
            req_data  = 32'hA1B2_C3D4 ^ {8{4'(m)}};
            @(negedge clk);
            check_result(1'b1, req_end, req_addr, req_data);
        end
        // R7: result lasts one cycle after the strobe drops
        req_valid = 1'b0;
        @(negedge clk);
        check_result(1'b0, 1'b0, '0, '0);

        // Random mix of strobes and idle cycles (R2-R8)
        for (int k = 0; k < 400; k++) begin
            pv = req_valid; pe = req_end; pa = req_addr; pd = req_data;
            req_valid = ($urandom % 4) != 0;
            req_end   = $urandom % 2;
            req_addr  = $urandom;
            req_data  = $urandom;
            if (k > 0) check_result(pv, pe, pa, pd);
            @(negedge clk);
        end
        check_result(req_valid, req_end, req_addr, req_data);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule